// File: doc/BRIEF.md
# Phase-Accumulator Image Scaler

This block resizes a raster image in a stream. Pixels arrive one line at a time on a valid/ready input. They are stored in a single line buffer and read back as output lines of a programmed width. Each output pixel comes from a 16.16 fixed-point phase accumulator. Its integer part picks the left source pixel. The top eight fractional bits weight a two-tap linear blend of that pixel and its right neighbour. A second accumulator, advanced once per output row, picks which input line feeds each output row. Rows are repeated when upscaling and input lines are dropped when downscaling.

Software writes the sizes, the initial phases and the phase increments through a small write-only register port. The intended values are increment = (input << 16) / output and seed = (input << 15) / output, which is half an increment. The block derives a filter-table selection for each axis from the programmed size ratio. It also checks that the configuration is legal, and it falls back to an unmodified pass-through when scaling is switched off or the configuration is illegal.

Top module: `phase_scaler`

## Requirements
- R1: After reset, in_ready is 1, out_valid and cfg_err are 0, h_table is 0 and v_table is 8'h6A.
- R2: h_table is the band of the programmed width ratio: 0 if in ≤ out, 1 if in ≤ out + ⌊out/2⌋, 2 if in ≤ 2·out, 3 if in ≤ 2·out + ⌊3·out/4⌋, otherwise 4.
- R3: v_table is 8'h6A plus the band of the programmed height ratio (same thresholds as R2), so it ranges from 8'h6A to 8'h6E.
- R4: Output pixel k of a row has phase A = h_seed + k·h_step. out_src_x is min(A[31:16], in_w−1) and out_frac is A[15:8]. The accumulator reloads at every row start.
- R5: Output row r has phase B = v_seed + r·v_step. out_src_y is min(B[31:16], in_h−1) and out_vfrac is B[15:8]. The accumulator reloads at every frame start.
- R6: Each colour channel (8 bits, channel c at data bits [8c+7:8c]) equals (p0·(256−f) + p1·f) >> 8. Here p0 is the input pixel at out_src_x, p1 is the pixel at min(out_src_x+1, in_w−1), and f is out_frac.
- R7: With the enhancement control bit set, 128 is added to the blend sum before the shift, so the result rounds to nearest.
- R8: Channel 3 (bits [31:24]) is the alpha channel. When the alpha control bit is clear it copies p0 unblended. When the bit is set it is blended like the colour channels.
- R9: With the scale control bit clear, the output has in_w × in_h pixels equal to the input, with out_src_x equal to the column and out_frac equal to 0.
- R10: A frame that starts with a size below 4, in_w above MAX_W, a height above 4096, a downscale beyond 6× or an upscale beyond 64× sets cfg_err. cfg_err then stays set until reset, and every frame is passed through as in R9.
- R11: Each output row has exactly the output width in pixels, with out_eol on the last one. A frame has the output height in rows. out_sof marks only the first pixel of a frame.
- R12: in_ready is low whenever an output pixel is being produced.

Registers (reg_addr): 0 control {bit0 scale, bit1 alpha, bit2 enhancement}; 1 input size {height[31:16], width[15:0]}; 2 output size in the same layout; 3 h_seed; 4 h_step; 5 v_seed; 6 v_step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_data | input | 32 | Input pixel, four 8-bit channels |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 32 | Output pixel |
| out_sof | output | 1 | First pixel of an output frame |
| out_eol | output | 1 | Last pixel of an output row |
| out_src_x | output | 16 | Source column for this pixel |
| out_frac | output | 8 | Horizontal blend weight |
| out_src_y | output | 16 | Source line for this row |
| out_vfrac | output | 8 | Vertical phase fraction |
| h_table | output | 3 | Horizontal filter-table index |
| v_table | output | 8 | Vertical filter-table code |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The bench targets the band edges of the ratio selection, where equality must fall in the lower band. A design with an off-by-one comparison would report the next table at exactly 1.5×, 2× and 2.75×. The frame tests cover upscaling, where input lines must be repeated, and downscaling, where lines must be skipped. A wrong reload point for either accumulator would shift every later source index. The right-edge neighbour must clamp; otherwise the last pixel blends with stale buffer contents. The alpha, rounding, pass-through and sticky-error tests each compare exact pixel values, so a lost bit or a non-sticky flag shows up as a data mismatch.

// File: rtl/scl_pkg.sv
package scl_pkg;

  localparam int SZW = 16;
  localparam int PHW = 32;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_IN_SZ  = 4'd1;
  localparam logic [3:0] RA_OUT_SZ = 4'd2;
  localparam logic [3:0] RA_H_SEED = 4'd3;
  localparam logic [3:0] RA_H_STEP = 4'd4;
  localparam logic [3:0] RA_V_SEED = 4'd5;
  localparam logic [3:0] RA_V_STEP = 4'd6;

  typedef struct packed {
    logic           scale_en;
    logic           alpha_en;
    logic           enh_en;
    logic [SZW-1:0] in_w;
    logic [SZW-1:0] in_h;
    logic [SZW-1:0] out_w;
    logic [SZW-1:0] out_h;
    logic [PHW-1:0] h_seed;
    logic [PHW-1:0] h_step;
    logic [PHW-1:0] v_seed;
    logic [PHW-1:0] v_step;
  } scl_cfg_t;

  // Ratio band 0..4; equality falls into the lower band.
  function automatic logic [2:0] ratio_band(input logic [SZW-1:0] isz,
                                            input logic [SZW-1:0] osz);
    logic [19:0] i;
    logic [19:0] o;
    i = {4'd0, isz};
    o = {4'd0, osz};
    if (i <= o)                                  return 3'd0;
    else if (i <= o + (o >> 1))                  return 3'd1;
    else if (i <= (o << 1))                      return 3'd2;
    else if (i <= (o << 1) + ((o * 20'd3) >> 2)) return 3'd3;
    else                                         return 3'd4;
  endfunction

  // Legal size pair for one axis.
  function automatic logic axis_ok(input logic [SZW-1:0] isz,
                                   input logic [SZW-1:0] osz,
                                   input int unsigned    max_in,
                                   input int unsigned    max_out,
                                   input int unsigned    dn_lim,
                                   input int unsigned    up_lim);
    logic [31:0] i;
    logic [31:0] o;
    i = {16'd0, isz};
    o = {16'd0, osz};
    return (i >= 32'd4) && (o >= 32'd4) && (i <= max_in) && (o <= max_out) &&
           (i <= o * dn_lim) && (o <= i * up_lim);
  endfunction

endpackage

// File: rtl/scl_regs.sv
module scl_regs
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [31:0] wdata,
  output scl_cfg_t   cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        RA_CTRL: begin
          cfg.scale_en <= wdata[0];
          cfg.alpha_en <= wdata[1];
          cfg.enh_en   <= wdata[2];
        end
        RA_IN_SZ: begin
          cfg.in_w <= wdata[15:0];
          cfg.in_h <= wdata[31:16];
        end
        RA_OUT_SZ: begin
          cfg.out_w <= wdata[15:0];
          cfg.out_h <= wdata[31:16];
        end
        RA_H_SEED: cfg.h_seed <= wdata;
        RA_H_STEP: cfg.h_step <= wdata;
        RA_V_SEED: cfg.v_seed <= wdata;
        RA_V_STEP: cfg.v_step <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/scl_phase.sv
module scl_phase #(
  parameter int PW  = 32,
  parameter int FW  = 16,
  parameter int IW  = 16,
  parameter int WFW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           adv,
  input  logic [PW-1:0]  seed,
  input  logic [PW-1:0]  step,
  input  logic [IW-1:0]  last,
  output logic [IW-1:0]  idx,
  output logic [WFW-1:0] frac
);

  logic [PW-1:0] acc_q;
  logic [PW-1:0] whole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= seed;
    else if (adv)  acc_q <= acc_q + step;
  end

  assign whole = acc_q >> FW;
  assign idx   = (whole > PW'(last)) ? last : whole[IW-1:0];
  assign frac  = acc_q[FW-1 -: WFW];

endmodule

// File: rtl/scl_linebuf.sv
module scl_linebuf #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/scl_blend.sv
module scl_blend #(
  parameter int CH  = 4,
  parameter int CW  = 8,
  parameter int FRW = 8,
  localparam int PXW = CH * CW,
  localparam int SW  = CW + FRW + 1
) (
  input  logic [PXW-1:0] p0,
  input  logic [PXW-1:0] p1,
  input  logic [FRW-1:0] frac,
  input  logic           rnd,
  input  logic           alpha_en,
  output logic [PXW-1:0] q
);

  localparam logic [SW-1:0] ONE = SW'(1) << FRW;

  function automatic logic [CW-1:0] mix(input logic [CW-1:0] a,
                                        input logic [CW-1:0] b,
                                        input logic [FRW-1:0] f,
                                        input logic r);
    logic [SW-1:0] s;
    s = SW'(a) * (ONE - SW'(f)) + SW'(b) * SW'(f) + (r ? (ONE >> 1) : '0);
    return s[FRW +: CW];
  endfunction

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [CW-1:0] a;
    logic [CW-1:0] b;
    assign a = p0[c*CW +: CW];
    assign b = p1[c*CW +: CW];
    if (c == CH - 1) begin : g_alpha
      assign q[c*CW +: CW] = alpha_en ? mix(a, b, frac, rnd) : a;
    end else begin : g_col
      assign q[c*CW +: CW] = mix(a, b, frac, rnd);
    end
  end

endmodule

// File: rtl/phase_scaler.sv
module phase_scaler
  import scl_pkg::*;
#(
  parameter int CH      = 4,
  parameter int CW      = 8,
  parameter int MAX_W   = 64,
  parameter int MAX_H   = 4096,
  parameter int DN_LIM  = 6,
  parameter int UP_LIM  = 64,
  localparam int PXW    = CH * CW,
  localparam int AW     = $clog2(MAX_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [PXW-1:0] in_data,
  output logic           out_valid,
  output logic [PXW-1:0] out_data,
  output logic           out_sof,
  output logic           out_eol,
  output logic [15:0]    out_src_x,
  output logic [7:0]     out_frac,
  output logic [15:0]    out_src_y,
  output logic [7:0]     out_vfrac,
  output logic [2:0]     h_table,
  output logic [7:0]     v_table,
  output logic           cfg_err
);

  typedef enum logic [1:0] {S_FILL, S_DECIDE, S_EMIT} st_t;

  localparam logic [PHW-1:0] UNIT_STEP = PHW'(1) << 16;

  st_t        st;
  scl_cfg_t   cfg;
  logic       err_q;
  logic       cfg_bad, bypass;
  logic [SZW-1:0] eff_out_w, eff_out_h;
  logic [PHW-1:0] eff_h_seed, eff_h_step, eff_v_seed, eff_v_step;
  logic [SZW-1:0] x_wr, y_cnt, ox, oy;
  logic [SZW-1:0] w_last, h_last;
  logic       accept, frame_head, line_done, row_go, last_line, px_last;
  logic       row_start, h_adv, v_load, v_adv;
  logic [15:0] h_idx, v_idx, h_nxt;
  logic [7:0]  h_frac, v_frac;
  logic [PXW-1:0] pix_a, pix_b, mixed;

  scl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  // Filter-table selection from the programmed ratio
  assign h_table = ratio_band(cfg.in_w, cfg.out_w);
  assign v_table = 8'h6A + {5'd0, ratio_band(cfg.in_h, cfg.out_h)};

  // Legality and mode
  assign cfg_bad = !(axis_ok(cfg.in_w, cfg.out_w, MAX_W, 32'hFFFF, DN_LIM, UP_LIM) &&
                     axis_ok(cfg.in_h, cfg.out_h, MAX_H, MAX_H, DN_LIM, UP_LIM));
  assign bypass  = !cfg.scale_en || cfg_bad || err_q;
  assign cfg_err = err_q;

  assign eff_out_w  = bypass ? cfg.in_w : cfg.out_w;
  assign eff_out_h  = bypass ? cfg.in_h : cfg.out_h;
  assign eff_h_seed = bypass ? '0 : cfg.h_seed;
  assign eff_h_step = bypass ? UNIT_STEP : cfg.h_step;
  assign eff_v_seed = bypass ? '0 : cfg.v_seed;
  assign eff_v_step = bypass ? UNIT_STEP : cfg.v_step;

  assign w_last = cfg.in_w - 16'd1;
  assign h_last = cfg.in_h - 16'd1;

  // Named internal events
  assign in_ready   = (st == S_FILL);
  assign accept     = in_valid && in_ready;
  assign frame_head = (st == S_FILL) && (y_cnt == '0) && (x_wr == '0);
  assign line_done  = accept && (x_wr == w_last);
  assign row_go     = (oy < eff_out_h) && (v_idx <= y_cnt);
  assign last_line  = (y_cnt == h_last);
  assign px_last    = (ox == eff_out_w - 16'd1);
  assign row_start  = (st == S_DECIDE) && row_go;
  assign h_adv      = (st == S_EMIT);
  assign v_load     = frame_head;
  assign v_adv      = (st == S_EMIT) && px_last;

  scl_phase #(.PW(PHW), .FW(16), .IW(16), .WFW(8)) u_hphase (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (row_start),
    .adv   (h_adv),
    .seed  (eff_h_seed),
    .step  (eff_h_step),
    .last  (w_last),
    .idx   (h_idx),
    .frac  (h_frac)
  );

  scl_phase #(.PW(PHW), .FW(16), .IW(16), .WFW(8)) u_vphase (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (v_load),
    .adv   (v_adv),
    .seed  (eff_v_seed),
    .step  (eff_v_step),
    .last  (h_last),
    .idx   (v_idx),
    .frac  (v_frac)
  );

  assign h_nxt = (h_idx >= w_last) ? h_idx : h_idx + 16'd1;

  scl_linebuf #(.DEPTH(MAX_W), .W(PXW)) u_line (
    .clk     (clk),
    .we      (accept),
    .waddr   (x_wr[AW-1:0]),
    .wdata   (in_data),
    .raddr_a (h_idx[AW-1:0]),
    .raddr_b (h_nxt[AW-1:0]),
    .rdata_a (pix_a),
    .rdata_b (pix_b)
  );

  scl_blend #(.CH(CH), .CW(CW), .FRW(8)) u_blend (
    .p0       (pix_a),
    .p1       (pix_b),
    .frac     (h_frac),
    .rnd      (cfg.enh_en),
    .alpha_en (cfg.alpha_en),
    .q        (mixed)
  );

  // Line/row sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_FILL;
      x_wr  <= '0;
      y_cnt <= '0;
      ox    <= '0;
      oy    <= '0;
      err_q <= 1'b0;
    end else begin
      if (frame_head && accept && cfg_bad) err_q <= 1'b1;
      case (st)
        S_FILL: begin
          if (accept) begin
            if (line_done) begin
              x_wr <= '0;
              st   <= S_DECIDE;
            end else begin
              x_wr <= x_wr + 16'd1;
            end
          end
        end
        S_DECIDE: begin
          if (row_go) begin
            ox <= '0;
            st <= S_EMIT;
          end else if (last_line) begin
            y_cnt <= '0;
            oy    <= '0;
            st    <= S_FILL;
          end else begin
            y_cnt <= y_cnt + 16'd1;
            st    <= S_FILL;
          end
        end
        S_EMIT: begin
          if (px_last) begin
            oy <= oy + 16'd1;
            st <= S_DECIDE;
          end else begin
            ox <= ox + 16'd1;
          end
        end
        default: st <= S_FILL;
      endcase
    end
  end

  // Registered output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_src_x <= '0;
      out_frac  <= '0;
      out_src_y <= '0;
      out_vfrac <= '0;
    end else begin
      out_valid <= (st == S_EMIT);
      out_sof   <= (st == S_EMIT) && (ox == '0) && (oy == '0);
      out_eol   <= (st == S_EMIT) && px_last;
      if (st == S_EMIT) begin
        out_data  <= mixed;
        out_src_x <= h_idx;
        out_frac  <= h_frac;
        out_src_y <= v_idx;
        out_vfrac <= v_frac;
      end
    end
  end

endmodule

// File: rtl/phase_scaler_chk.sv
module phase_scaler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_sof,
  input logic        out_eol,
  input logic [15:0] out_src_x,
  input logic        cfg_err,
  input logic [2:0]  h_table,
  input logic [7:0]  v_table,
  input logic        row_start
);

  // R2: horizontal table index stays within five bands
  a_r2_band_range: assert property (@(posedge clk) disable iff (!rst_n)
    h_table <= 3'd4);

  // R3: vertical code stays within 6A..6E
  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (v_table >= 8'h6A) && (v_table <= 8'h6E));

  // R4: source column never moves backwards inside a row
  a_r4_src_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eol) |=> (out_valid && (out_src_x >= $past(out_src_x))));

  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R11: markers only on valid pixels, a gap follows every row end
  a_r11_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r11_eol_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |=> !out_valid);
  a_r11_row_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> !out_valid);

  // R12: no input accepted while output is produced
  a_r12_no_ready_on_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

endmodule

bind phase_scaler phase_scaler_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_eol   (out_eol),
  .out_src_x (out_src_x),
  .cfg_err   (cfg_err),
  .h_table   (h_table),
  .v_table   (v_table),
  .row_start (row_start)
);

// File: tb/sim_phase_scaler.sv
module sim_phase_scaler;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_sof, out_eol;
  logic [15:0] out_src_x, out_src_y;
  logic [7:0]  out_frac, out_vfrac;
  logic [2:0]  h_table;
  logic [7:0]  v_table;
  logic        cfg_err;

  phase_scaler u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .out_src_x(out_src_x),
    .out_frac(out_frac), .out_src_y(out_src_y), .out_vfrac(out_vfrac),
    .h_table(h_table), .v_table(v_table), .cfg_err(cfg_err)
  );

  int errors = 0;
  int checks = 0;
  int n_cap = 0;
  int overlap = 0;
  logic [31:0] img   [0:4095];
  logic [31:0] cap_d [0:8191];
  logic [15:0] cap_x [0:8191];
  logic [15:0] cap_y [0:8191];
  logic [7:0]  cap_f [0:8191];
  logic [7:0]  cap_vf[0:8191];
  logic        cap_s [0:8191];
  logic        cap_e [0:8191];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (n_cap < 8192) begin
        cap_d[n_cap] = out_data;  cap_x[n_cap] = out_src_x; cap_y[n_cap] = out_src_y;
        cap_f[n_cap] = out_frac;  cap_vf[n_cap] = out_vfrac;
        cap_s[n_cap] = out_sof;   cap_e[n_cap] = out_eol;
      end
      n_cap = n_cap + 1;
      if (in_ready) overlap = overlap + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] pix(input int x, input int y, input int pat);
    logic [31:0] p;
    for (int c = 0; c < 4; c++)
      p[c*8 +: 8] = 8'((x * 37 + y * 91 + c * 53 + pat * 17 + x * y * 5) & 255);
    return p;
  endfunction

  // Expected band, written with a four-times scale
  function automatic int exp_band(input int i, input int o);
    if (4 * i <= 4 * o) return 0;
    if (4 * i <= 6 * o) return 1;
    if (4 * i <= 8 * o) return 2;
    if (4 * i <= 11 * o) return 3;
    return 4;
  endfunction

  task automatic send_frame(input int iw, input int ih, input int pat);
    for (int y = 0; y < ih; y++)
      for (int x = 0; x < iw; x++) img[y * iw + x] = pix(x, y, pat);
    for (int y = 0; y < ih; y++) begin
      for (int x = 0; x < iw; x++) begin
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = img[y * iw + x];
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic wait_out(input int base, input int n);
    int k;
    k = 0;
    while ((n_cap - base) < n && k < 20000) begin
      @(negedge clk);
      k++;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic check_frame(input int iw, input int ih, input int ow, input int oh,
                             input logic [31:0] hs, input logic [31:0] hst,
                             input logic [31:0] vs, input logic [31:0] vst,
                             input logic aen, input logic enh, input int base,
                             input string req);
    int bd, bx, by, bm;
    longint fa_d, fe_d, fa_x, fe_x, fa_y, fe_y;
    bd = 0; bx = 0; by = 0; bm = 0;
    fa_d = 0; fe_d = 0; fa_x = 0; fe_x = 0; fa_y = 0; fe_y = 0;
    chk((n_cap - base) == ow * oh, req, "R11 pixel count", n_cap - base, ow * oh);
    for (int r = 0; r < oh; r++) begin
      logic [31:0] va;
      int sy;
      va = vs + 32'(r) * vst;
      sy = int'(va >> 16);
      if (sy > ih - 1) sy = ih - 1;
      for (int k = 0; k < ow; k++) begin
        logic [31:0] ha, p0, p1, e;
        int sx, sx1, f, n;
        ha = hs + 32'(k) * hst;
        sx = int'(ha >> 16);
        if (sx > iw - 1) sx = iw - 1;
        sx1 = (sx + 1 > iw - 1) ? iw - 1 : sx + 1;
        f = int'(ha[15:8]);
        p0 = img[sy * iw + sx];
        p1 = img[sy * iw + sx1];
        for (int c = 0; c < 4; c++) begin
          int a, b;
          a = int'(p0[c*8 +: 8]);
          b = int'(p1[c*8 +: 8]);
          if (c == 3 && !aen) e[c*8 +: 8] = 8'(a);
          else e[c*8 +: 8] = 8'((a * (256 - f) + b * f + (enh ? 128 : 0)) / 256);
        end
        n = base + r * ow + k;
        if (n < 8192 && n < n_cap) begin
          if (cap_d[n] !== e) begin
            if (bd == 0) begin fa_d = cap_d[n]; fe_d = e; end
            bd++;
          end
          if (cap_x[n] !== 16'(sx) || cap_f[n] !== 8'(f)) begin
            if (bx == 0) begin fa_x = {cap_x[n], cap_f[n]}; fe_x = {16'(sx), 8'(f)}; end
            bx++;
          end
          if (cap_y[n] !== 16'(sy) || cap_vf[n] !== va[15:8]) begin
            if (by == 0) begin fa_y = {cap_y[n], cap_vf[n]}; fe_y = {16'(sy), va[15:8]}; end
            by++;
          end
          if (cap_s[n] !== (r == 0 && k == 0) || cap_e[n] !== (k == ow - 1)) bm++;
        end
      end
    end
    chk(bd == 0, req, "R6 pixel data", fa_d, fe_d);
    chk(bx == 0, req, "R4 src_x/frac", fa_x, fe_x);
    chk(by == 0, req, "R5 src_y/vfrac", fa_y, fe_y);
    chk(bm == 0, req, "R11 sof/eol markers", bm, 0);
  endtask

  task automatic run_frame(input int iw, input int ih, input int ow, input int oh,
                           input logic [2:0] ctrl, input int pat, input logic pass,
                           input string req);
    logic [31:0] hs, hst, vs, vst;
    int base;
    hst = (32'(iw) << 16) / 32'(ow);
    hs  = (32'(iw) << 15) / 32'(ow);
    vst = (32'(ih) << 16) / 32'(oh);
    vs  = (32'(ih) << 15) / 32'(oh);
    wreg(4'd1, {16'(ih), 16'(iw)});
    wreg(4'd2, {16'(oh), 16'(ow)});
    wreg(4'd3, hs);
    wreg(4'd4, hst);
    wreg(4'd5, vs);
    wreg(4'd6, vst);
    wreg(4'd0, {29'd0, ctrl});
    base = n_cap;
    send_frame(iw, ih, pat);
    if (pass) begin
      wait_out(base, iw * ih);
      check_frame(iw, ih, iw, ih, 32'd0, 32'h1_0000, 32'd0, 32'h1_0000,
                  ctrl[1], ctrl[2], base, req);
    end else begin
      wait_out(base, ow * oh);
      check_frame(iw, ih, ow, oh, hs, hst, vs, vst, ctrl[1], ctrl[2], base, req);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);
    chk(h_table == 3'd0 && v_table == 8'h6A, "R1", "tables", {h_table, v_table}, 8'h6A);
  endtask

  task automatic t_tables();
    int ins [7] = '{8, 12, 13, 16, 22, 23, 4};
    for (int i = 0; i < 7; i++) begin
      int j, eh, ev;
      j = (i + 3) % 7;
      wreg(4'd1, {16'(ins[j]), 16'(ins[i])});
      wreg(4'd2, {16'd8, 16'd8});
      @(negedge clk);
      eh = exp_band(ins[i], 8);
      ev = 8'h6A + exp_band(ins[j], 8);
      chk(h_table == 3'(eh), "R2", "h_table", h_table, eh);
      chk(v_table == 8'(ev), "R3", "v_table", v_table, ev);
    end
  endtask

  // R4 R5 R6 R11: upscaling, rows repeated
  task automatic t_upscale();
    run_frame(4, 4, 8, 6, 3'b011, 1, 1'b0, "R4 R5 up");
  endtask

  // R4 R5 R6: downscaling, lines skipped
  task automatic t_downscale();
    run_frame(12, 8, 4, 4, 3'b011, 2, 1'b0, "R4 R5 down");
  endtask

  // R7 R8: rounding on, alpha copied
  task automatic t_enh_alpha();
    run_frame(5, 4, 7, 5, 3'b101, 3, 1'b0, "R7 R8");
  endtask

  // R9: scale bit clear passes the input unchanged
  task automatic t_bypass();
    run_frame(6, 4, 9, 9, 3'b110, 4, 1'b1, "R9");
    chk(cfg_err == 1'b0, "R9", "no error in bypass", cfg_err, 0);
  endtask

  // R10: illegal width sets sticky error and forces pass-through
  task automatic t_illegal();
    run_frame(3, 4, 8, 8, 3'b011, 5, 1'b1, "R10 bad");
    chk(cfg_err == 1'b1, "R10", "cfg_err set", cfg_err, 1);
    run_frame(4, 4, 8, 6, 3'b011, 6, 1'b1, "R10 sticky");
    chk(cfg_err == 1'b1, "R10", "cfg_err held", cfg_err, 1);
  endtask

  task automatic t_ready();
    chk(overlap == 0, "R12", "ready during output", overlap, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tables();
    t_upscale();
    t_downscale();
    t_enh_alpha();
    t_bypass();
    t_ready();
    t_illegal();
    summary();
  end

endmodule